// File: doc/BRIEF.md
# Transaction Status Controller

This block is the per-processor bookkeeping for hardware transactions. It holds two flags: one telling whether a transaction is in progress, and one telling whether that transaction is still alive or has been killed. It watches a stream of decoded transactional instructions, given as a valid strobe and an opcode. It answers the status query and the commit with a single result bit. It drives one-cycle commit and abort pulses toward the transactional cache, which turns those pulses into its tag changes.

No instruction opens a transaction. The first transactional load, exclusive load or store opens it. From then on the transaction is killed by any of three things: a refused transactional fill from another cache, an interrupt, or a transactional cache overflow. A killed transaction stays marked dead. Its later accesses issue no bus traffic. A status query, a commit or an explicit abort returns the controller to idle. A commit on a dead transaction reports failure and sends no commit pulse, because the abort pulse has already been sent.

Top module: `txn_state_ctrl`

## Requirements
- R1: After reset, `txn_active` is 0, `txn_alive` is 1, and `xfer_go`, `rslt_vld`, `rslt_bit`, `commit_pulse` and `abort_pulse` are all 0.
- R2: A load (opcode 1), exclusive load (opcode 2) or store (opcode 3) issued while idle sets `txn_active` and leaves `txn_alive` at 1. An access from a live transaction pulses `xfer_go` for one cycle.
- R3: If `fill_busy`, `intr_req` or `tcache_ovf` is high while a transaction is active and alive, `txn_alive` is cleared, `txn_active` stays 1 and `abort_pulse` fires once. The same inputs have no effect while idle or when the transaction is already dead.
- R4: Accesses from a dead transaction give no `xfer_go` and leave both flags unchanged.
- R5: A status query (opcode 4) raises `rslt_vld` and returns the alive flag on `rslt_bit`. When that value is 0, it also clears `txn_active` and sets `txn_alive`. When it is 1, the flags are unchanged.
- R6: A commit (opcode 5) on an active, alive transaction returns 1, pulses `commit_pulse` and clears `txn_active`.
- R7: A commit on a dead transaction returns 0, sends no commit pulse and no new abort pulse, and leaves the flags at idle (active 0, alive 1).
- R8: An abort (opcode 6) returns the flags to idle. It pulses `abort_pulse` only if the transaction was active and alive.
- R9: A kill event arriving in the same cycle as an instruction takes effect first. A commit then returns 0 with no commit pulse. An access then gives no `xfer_go`. Exactly one abort pulse is sent.
- R10: Opcodes 0 and 7, and any opcode while `instr_vld` is 0, change nothing and produce no result or pulse.
- R11: Every output is registered and reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction strobe |
| instr_op | input | OP_W (3) | Transactional opcode |
| fill_busy | input | 1 | Transactional fill refused by another cache |
| intr_req | input | 1 | Interrupt taken |
| tcache_ovf | input | 1 | Transactional cache overflow |
| xfer_go | output | 1 | Access may issue its bus cycle |
| rslt_vld | output | 1 | Result bit valid (query or commit) |
| rslt_bit | output | 1 | Query or commit result, 1 = alive/success |
| commit_pulse | output | 1 | Cache commit action |
| abort_pulse | output | 1 | Cache abort action |
| txn_active | output | 1 | Transaction in progress |
| txn_alive | output | 1 | Transaction not killed |

## Verification
Every result, pulse and flag change is due exactly one rising edge after the instruction or event is sampled. The bench drives its inputs shortly after a rising edge and reads the outputs at the following falling edge, one full sampling edge later. A behavioural model in the bench is advanced on the same edge and compared against the outputs every cycle. Directed checks after each scripted step pin the same-cycle priority of kill events, the dead-commit case and the ignored opcodes to fixed expected values.

// File: rtl/txn_ctrl_pkg.sv
package txn_ctrl_pkg;
  parameter int OP_W  = 3;
  parameter int EVT_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = OP_W'(0),
    OP_RD     = OP_W'(1),
    OP_RDX    = OP_W'(2),
    OP_WR     = OP_W'(3),
    OP_CHECK  = OP_W'(4),
    OP_COMMIT = OP_W'(5),
    OP_ABORT  = OP_W'(6),
    OP_RSVD   = OP_W'(7)
  } txn_op_e;

  typedef struct packed {
    logic acc;
    logic chk;
    logic cmt;
    logic abt;
  } txn_dec_t;
endpackage

// File: rtl/txn_rst_sync.sv
module txn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg[STAGES-1];
endmodule

// File: rtl/txn_op_decode.sv
module txn_op_decode
  import txn_ctrl_pkg::*;
(
  input  logic            instr_vld,
  input  logic [OP_W-1:0] instr_op,
  output txn_dec_t        dec
);
  always_comb begin
    dec = '0;
    if (instr_vld) begin
      case (txn_op_e'(instr_op))
        OP_RD, OP_RDX, OP_WR: dec.acc = 1'b1;
        OP_CHECK:             dec.chk = 1'b1;
        OP_COMMIT:            dec.cmt = 1'b1;
        OP_ABORT:             dec.abt = 1'b1;
        default:              dec     = '0;
      endcase
    end
  end
endmodule

// File: rtl/txn_flag_reg.sv
module txn_flag_reg
  import txn_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  txn_dec_t         dec,
  input  logic [EVT_W-1:0] evt,
  output logic             active,
  output logic             alive,
  output logic             kill,
  output logic             live_eff
);
  logic act_nxt, alv_nxt, flag_en;

  // kill events only matter for a live, open transaction
  assign kill     = active & alive & (|evt);
  assign live_eff = alive & ~kill;

  always_comb begin
    act_nxt = active;
    alv_nxt = alive;
    if (kill)                 alv_nxt = 1'b0;
    if (dec.acc)              act_nxt = 1'b1;
    if (dec.chk && !live_eff) begin
      act_nxt = 1'b0;
      alv_nxt = 1'b1;
    end
    if (dec.cmt || dec.abt) begin
      act_nxt = 1'b0;
      alv_nxt = 1'b1;
    end
    flag_en = (act_nxt != active) || (alv_nxt != alive);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      alive  <= 1'b1;
    end else if (flag_en) begin
      active <= act_nxt;
      alive  <= alv_nxt;
    end
  end
endmodule

// File: rtl/txn_resp_gen.sv
module txn_resp_gen
  import txn_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  txn_dec_t dec,
  input  logic     active,
  input  logic     alive,
  input  logic     kill,
  input  logic     live_eff,
  output logic     xfer_go,
  output logic     rslt_vld,
  output logic     rslt_bit,
  output logic     commit_pulse,
  output logic     abort_pulse
);
  logic go_n, rv_n, rb_n, cp_n, ap_n;

  always_comb begin
    go_n = dec.acc & live_eff;
    rv_n = dec.chk | dec.cmt;
    rb_n = (dec.chk | dec.cmt) & live_eff;
    cp_n = dec.cmt & active & live_eff;
    ap_n = kill | (dec.abt & active & alive);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_go      <= 1'b0;
      rslt_vld     <= 1'b0;
      rslt_bit     <= 1'b0;
      commit_pulse <= 1'b0;
      abort_pulse  <= 1'b0;
    end else begin
      xfer_go      <= go_n;
      rslt_vld     <= rv_n;
      rslt_bit     <= rb_n;
      commit_pulse <= cp_n;
      abort_pulse  <= ap_n;
    end
  end
endmodule

// File: rtl/txn_state_ctrl.sv
module txn_state_ctrl
  import txn_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_vld,
  input  logic [OP_W-1:0] instr_op,
  input  logic            fill_busy,
  input  logic            intr_req,
  input  logic            tcache_ovf,
  output logic            xfer_go,
  output logic            rslt_vld,
  output logic            rslt_bit,
  output logic            commit_pulse,
  output logic            abort_pulse,
  output logic            txn_active,
  output logic            txn_alive
);
  logic             rst_sync_n;
  txn_dec_t         dec;
  logic [EVT_W-1:0] evt;
  logic             kill, live_eff;

  assign evt = {tcache_ovf, intr_req, fill_busy};

  txn_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  txn_op_decode u_dec (
    .instr_vld(instr_vld), .instr_op(instr_op), .dec(dec)
  );

  txn_flag_reg u_flags (
    .clk(clk), .rst_n(rst_sync_n), .dec(dec), .evt(evt),
    .active(txn_active), .alive(txn_alive),
    .kill(kill), .live_eff(live_eff)
  );

  txn_resp_gen u_resp (
    .clk(clk), .rst_n(rst_sync_n), .dec(dec),
    .active(txn_active), .alive(txn_alive),
    .kill(kill), .live_eff(live_eff),
    .xfer_go(xfer_go), .rslt_vld(rslt_vld), .rslt_bit(rslt_bit),
    .commit_pulse(commit_pulse), .abort_pulse(abort_pulse)
  );
endmodule

// File: rtl/txn_state_ctrl_chk.sv
module txn_state_ctrl_chk
  import txn_ctrl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            instr_vld,
  input logic [OP_W-1:0] instr_op,
  input logic            fill_busy,
  input logic            intr_req,
  input logic            tcache_ovf,
  input logic            xfer_go,
  input logic            rslt_vld,
  input logic            commit_pulse,
  input logic            abort_pulse,
  input logic            txn_active,
  input logic            txn_alive
);
  AST_IDLE_IS_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_active |-> txn_alive); // R5

  AST_KILL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_active && txn_alive && (fill_busy || intr_req || tcache_ovf))
      |=> (abort_pulse && !commit_pulse)); // R3

  AST_DEAD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_active && !txn_alive) |=> !xfer_go); // R4

  AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld && instr_op == OP_COMMIT) |=> (rslt_vld && !txn_active && txn_alive)); // R6

  AST_COMMIT_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> $past(txn_active && txn_alive)); // R7

  AST_RESULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_vld |-> $past(instr_vld && (instr_op == OP_CHECK || instr_op == OP_COMMIT))); // R10

  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pulse && abort_pulse)); // R9
endmodule

bind txn_state_ctrl txn_state_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_op(instr_op),
  .fill_busy(fill_busy), .intr_req(intr_req), .tcache_ovf(tcache_ovf),
  .xfer_go(xfer_go), .rslt_vld(rslt_vld), .commit_pulse(commit_pulse),
  .abort_pulse(abort_pulse), .txn_active(txn_active), .txn_alive(txn_alive)
);

// File: tb/txn_state_ctrl_bench.sv
module txn_state_ctrl_bench;
  import txn_ctrl_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_vld = 1'b0;
  logic [OP_W-1:0] instr_op = '0;
  logic fill_busy = 1'b0, intr_req = 1'b0, tcache_ovf = 1'b0;
  logic xfer_go, rslt_vld, rslt_bit, commit_pulse, abort_pulse, txn_active, txn_alive;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  txn_state_ctrl u_txn_state_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_op(instr_op),
    .fill_busy(fill_busy), .intr_req(intr_req), .tcache_ovf(tcache_ovf),
    .xfer_go(xfer_go), .rslt_vld(rslt_vld), .rslt_bit(rslt_bit),
    .commit_pulse(commit_pulse), .abort_pulse(abort_pulse),
    .txn_active(txn_active), .txn_alive(txn_alive)
  );

  // behavioural reference model
  bit m_act, m_alv, m_go, m_rv, m_rb, m_cp, m_ap;
  bit t_k, t_le, t_act, t_alv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_alv <= 1; m_go <= 0; m_rv <= 0; m_rb <= 0; m_cp <= 0; m_ap <= 0;
    end else begin
      t_k   = m_act && m_alv && (fill_busy || intr_req || tcache_ovf);
      t_le  = m_alv && !t_k;
      t_act = m_act;
      t_alv = t_k ? 1'b0 : m_alv;
      m_go <= 0; m_rv <= 0; m_rb <= 0; m_cp <= 0;
      m_ap <= t_k;
      if (instr_vld) begin
        if (instr_op >= 1 && instr_op <= 3) begin
          t_act = 1; m_go <= t_le;
        end else if (instr_op == 4) begin
          m_rv <= 1; m_rb <= t_le;
          if (!t_le) begin t_act = 0; t_alv = 1; end
        end else if (instr_op == 5) begin
          m_rv <= 1; m_rb <= t_le; m_cp <= m_act && t_le;
          t_act = 0; t_alv = 1;
        end else if (instr_op == 6) begin
          m_ap <= t_k || (m_act && m_alv);
          t_act = 0; t_alv = 1;
        end
      end
      m_act <= t_act;
      m_alv <= t_alv;
    end
  end

  task automatic cmp(string nm, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R11 %s per-cycle: actual=%b expected=%b at %0t", nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("xfer_go", xfer_go, m_go);
      cmp("rslt_vld", rslt_vld, m_rv);
      cmp("rslt_bit", rslt_bit, m_rb);
      cmp("commit_pulse", commit_pulse, m_cp);
      cmp("abort_pulse", abort_pulse, m_ap);
      cmp("txn_active", txn_active, m_act);
      cmp("txn_alive", txn_alive, m_alv);
    end
  end

  task automatic dchk(string req, string nm, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // one instruction/event cycle; returns at the falling edge where its results show
  task automatic step(logic v, logic [OP_W-1:0] op, logic b, logic i, logic o);
    @(posedge clk); #2;
    instr_vld = v; instr_op = op; fill_busy = b; intr_req = i; tcache_ovf = o;
    @(posedge clk); #2;
    instr_vld = 0; instr_op = '0; fill_busy = 0; intr_req = 0; tcache_ovf = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    dchk("R1", "txn_active", txn_active, 0);
    dchk("R1", "txn_alive", txn_alive, 1);
    dchk("R1", "xfer_go", xfer_go, 0);
    dchk("R1", "rslt_vld", rslt_vld, 0);
    dchk("R1", "rslt_bit", rslt_bit, 0);
    dchk("R1", "commit_pulse", commit_pulse, 0);
    dchk("R1", "abort_pulse", abort_pulse, 0);

    // R2 implicit start, then R6 live commit
    step(1, 1, 0, 0, 0);
    dchk("R2", "txn_active", txn_active, 1);
    dchk("R2", "txn_alive", txn_alive, 1);
    dchk("R2", "xfer_go", xfer_go, 1);
    step(1, 3, 0, 0, 0);
    dchk("R2", "xfer_go store", xfer_go, 1);
    step(1, 5, 0, 0, 0);
    dchk("R6", "rslt_vld", rslt_vld, 1);
    dchk("R6", "rslt_bit", rslt_bit, 1);
    dchk("R6", "commit_pulse", commit_pulse, 1);
    dchk("R6", "abort_pulse", abort_pulse, 0);
    dchk("R6", "txn_active", txn_active, 0);

    // R3 busy kill, R4 dead access, R5 failing query
    step(1, 2, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    dchk("R3", "abort_pulse", abort_pulse, 1);
    dchk("R3", "txn_alive", txn_alive, 0);
    dchk("R3", "txn_active", txn_active, 1);
    step(1, 3, 0, 0, 0);
    dchk("R4", "xfer_go", xfer_go, 0);
    dchk("R4", "txn_alive", txn_alive, 0);
    dchk("R4", "txn_active", txn_active, 1);
    step(0, 0, 0, 1, 0);
    dchk("R3", "abort_pulse when dead", abort_pulse, 0);
    step(1, 4, 0, 0, 0);
    dchk("R5", "rslt_vld", rslt_vld, 1);
    dchk("R5", "rslt_bit dead", rslt_bit, 0);
    dchk("R5", "txn_active", txn_active, 0);
    dchk("R5", "txn_alive", txn_alive, 1);
    step(1, 4, 0, 0, 0);
    dchk("R5", "rslt_bit idle", rslt_bit, 1);

    // R5 passing query, then R7 dead commit
    step(1, 1, 0, 0, 0);
    step(1, 4, 0, 0, 0);
    dchk("R5", "rslt_bit live", rslt_bit, 1);
    dchk("R5", "txn_active kept", txn_active, 1);
    step(0, 0, 0, 1, 0);
    dchk("R3", "abort on intr", abort_pulse, 1);
    step(1, 5, 0, 0, 0);
    dchk("R7", "rslt_vld", rslt_vld, 1);
    dchk("R7", "rslt_bit", rslt_bit, 0);
    dchk("R7", "commit_pulse", commit_pulse, 0);
    dchk("R7", "abort_pulse", abort_pulse, 0);
    dchk("R7", "txn_active", txn_active, 0);
    dchk("R7", "txn_alive", txn_alive, 1);

    // R8 abort
    step(1, 1, 0, 0, 0);
    step(1, 6, 0, 0, 0);
    dchk("R8", "abort_pulse", abort_pulse, 1);
    dchk("R8", "commit_pulse", commit_pulse, 0);
    dchk("R8", "txn_active", txn_active, 0);
    step(1, 6, 0, 0, 0);
    dchk("R8", "abort_pulse idle", abort_pulse, 0);
    step(0, 0, 0, 0, 1);
    dchk("R3", "ovf while idle", abort_pulse, 0);
    dchk("R3", "ovf while idle active", txn_active, 0);

    // R9 same-cycle kill
    step(1, 1, 0, 0, 0);
    step(1, 5, 0, 0, 1);
    dchk("R9", "rslt_bit", rslt_bit, 0);
    dchk("R9", "commit_pulse", commit_pulse, 0);
    dchk("R9", "abort_pulse", abort_pulse, 1);
    dchk("R9", "txn_active", txn_active, 0);
    step(1, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0);
    dchk("R9", "xfer_go with busy", xfer_go, 0);
    dchk("R9", "abort_pulse", abort_pulse, 1);
    dchk("R9", "txn_alive", txn_alive, 0);
    step(1, 6, 0, 0, 0);
    dchk("R8", "abort on dead", abort_pulse, 0);

    // R10 ignored opcodes
    step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    dchk("R10", "op0 rslt_vld", rslt_vld, 0);
    dchk("R10", "op0 xfer_go", xfer_go, 0);
    step(1, 7, 0, 0, 0);
    dchk("R10", "op7 rslt_vld", rslt_vld, 0);
    dchk("R10", "op7 abort", abort_pulse, 0);
    step(0, 5, 0, 0, 0);
    dchk("R10", "no-vld commit", commit_pulse, 0);
    dchk("R10", "no-vld active", txn_active, 1);
    dchk("R10", "no-vld alive", txn_alive, 1);
    step(1, 6, 0, 0, 0);

    // R11 random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #2;
      instr_vld  = 1'($urandom_range(0, 1));
      instr_op   = OP_W'($urandom_range(0, 7));
      fill_busy  = ($urandom_range(0, 9) == 0);
      intr_req   = ($urandom_range(0, 19) == 0);
      tcache_ovf = ($urandom_range(0, 29) == 0);
    end
    @(posedge clk); #2;
    instr_vld = 0; fill_busy = 0; intr_req = 0; tcache_ovf = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule